// File: doc/BRIEF.md
# DRAM Strobe Decoder with 8:1 Compressed Parallel Test

This block sits on the device side of an asynchronous multiplexed-address DRAM interface and turns the row strobe, column strobe, write enable and output enable, sampled on a fast system clock, into array operations. Each falling edge of the row strobe is classified into one of three kinds. It is a row access when the column strobe is high. It is a counter refresh when the column strobe is already low and write enable is high. It is a test-mode entry when the column strobe and write enable are both low. The block keeps a test-mode flag and a refresh row counter.

The array is a small model organised as 8-bit words, each holding two 4-bit nibbles. In normal mode a column address bit 0 picks the nibble, and reads return the stored nibble. In test mode a write copies data input bit 0 into all eight bits of the word. A read returns a pass/fail flag instead of data: bits 2:0 are held at 1, and bit 3 is 1 only when all eight bits of the word agree. An all-ones output therefore means pass. Outputs are modelled as a data bus plus a drive-enable, so high impedance is `dout_en = 0`.

Top module: `dram_tm_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, the next cycle shows `dout_en` = 0, `test_active` = 0 and `ref_row` = 0.
- R2: In normal mode a row access followed by a column strobe fall with `we_n` high returns the nibble last written to that row and column. Column address bit 0 selects the low nibble (0) or high nibble (1) of a word, and the two nibbles are stored independently.
- R3: `dout_en` is 0 whenever `cas_n` or `oe_n` was high two clocks earlier. It is also 0 during a column cycle that wrote instead of reading.
- R4: A row strobe fall with `cas_n` and `we_n` both low sets `test_active` to 1 and leaves `ref_row` unchanged.
- R5: A row strobe fall with `cas_n` low and `we_n` high clears `test_active`, increments `ref_row` by one (modulo 2^10) and does not access the array. No other event changes `ref_row`.
- R6: A row cycle with `cas_n` high at the row strobe fall that ends with no column strobe fall clears `test_active`.
- R7: In test mode a write stores `din[0]` into all eight bits of the addressed word and ignores `din[3:1]`.
- R8: In test mode a read drives `dout` = 4'b1111 when all eight bits of the word are equal and 4'b0111 otherwise.
- R9: In test mode the top row address bit (bit 2), the top column address bit (bit 3) and column bit 0 do not affect which word is addressed.
- R10: Several column strobe falls within one row strobe low period each access their own column. A fall of `we_n` while `cas_n` is low in a normal row cycle writes `din` to the column latched at that column strobe fall.
- R11: A row strobe that rises and falls again while `cas_n` stays low after a read is a refresh (R5 applies), and `dout_en` and `dout` keep the read result throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 4 | Multiplexed row/column address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data or test-mode result |
| dout_en | output | 1 | Output drive enable; 0 means high impedance |
| test_active | output | 1 | Compressed test mode is on |
| ref_row | output | 10 | Internal refresh row counter |

## Verification
The hardest situation to reach is a fail result in test mode. Test-mode writes always store uniform words, so a mismatch can only come from data placed before entry. The bench writes nibbles of different value through normal cycles, enters test mode with a write-enable-and-column-before-row cycle, and reads the same word through aliased addresses that differ only in the ignored bits. The hidden refresh case is also delicate: the column strobe is held low across a full row strobe pulse after a read, and the bench checks that the output keeps driving while the counter advances and test mode drops.

// File: rtl/dram_tm_pkg.sv
`timescale 1ns/1ps
package dram_tm_pkg;
  // classification of one row strobe falling edge
  typedef enum logic [1:0] {
    CYC_IDLE       = 2'd0,
    CYC_ACCESS     = 2'd1,
    CYC_REFRESH    = 2'd2,
    CYC_TEST_ENTRY = 2'd3
  } ras_cycle_e;
endpackage

// File: rtl/strobe_front.sv
`timescale 1ns/1ps
module strobe_front
  import dram_tm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DQ_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   din,
  output logic              s_cas,
  output logic              s_we,
  output logic              s_oe,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DQ_W-1:0]   s_din,
  output logic              cas_fall,
  output logic              we_fall,
  output logic              ras_rise,
  output ras_cycle_e        ras_kind
);
  logic s_ras, p_ras, p_cas, p_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ras  <= 1'b1;
      s_cas  <= 1'b1;
      s_we   <= 1'b1;
      s_oe   <= 1'b1;
      p_ras  <= 1'b1;
      p_cas  <= 1'b1;
      p_we   <= 1'b1;
      s_addr <= '0;
      s_din  <= '0;
    end else begin
      s_ras  <= ras_n;
      s_cas  <= cas_n;
      s_we   <= we_n;
      s_oe   <= oe_n;
      p_ras  <= s_ras;
      p_cas  <= s_cas;
      p_we   <= s_we;
      s_addr <= addr;
      s_din  <= din;
    end
  end

  assign cas_fall = p_cas & ~s_cas;
  assign we_fall  = p_we & ~s_we;
  assign ras_rise = ~p_ras & s_ras;

  always_comb begin
    ras_kind = CYC_IDLE;
    if (p_ras & ~s_ras) begin
      if (s_cas)     ras_kind = CYC_ACCESS;
      else if (s_we) ras_kind = CYC_REFRESH;
      else           ras_kind = CYC_TEST_ENTRY;
    end
  end
endmodule

// File: rtl/tm_array.sv
`timescale 1ns/1ps
module tm_array #(
  parameter int LANES  = 2,
  parameter int DQ_W   = 4,
  parameter int WADR_W = 6
) (
  input  logic                  clk,
  input  logic [LANES-1:0]      wr_lane,
  input  logic                  rd_en,
  input  logic [WADR_W-1:0]     waddr,
  input  logic [LANES*DQ_W-1:0] wdata,
  output logic [LANES*DQ_W-1:0] rdata
);
  localparam int DEPTH = 1 << WADR_W;

  // one simple-dual-use RAM per nibble lane so each lane has its own write enable
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DQ_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_lane[g]) mem[waddr] <= wdata[g*DQ_W +: DQ_W];
      if (rd_en)      rdata[g*DQ_W +: DQ_W] <= mem[waddr];
    end
  end
endmodule

// File: rtl/tm_readout.sv
`timescale 1ns/1ps
module tm_readout #(
  parameter int LANES = 2,
  parameter int DQ_W  = 4,
  parameter int SEL_W = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cas_fall,
  input  logic                  rd_strobe,
  input  logic                  rd_test,
  input  logic [SEL_W-1:0]      rd_lane,
  input  logic                  s_cas,
  input  logic                  s_oe,
  input  logic [LANES*DQ_W-1:0] rdata,
  output logic [DQ_W-1:0]       dout,
  output logic                  dout_en
);
  logic             have_q, tm_q;
  logic [SEL_W-1:0] lane_q;
  logic             uniform;

  assign uniform = (&rdata) | ~(|rdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q  <= 1'b0;
      tm_q    <= 1'b0;
      lane_q  <= '0;
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      if (cas_fall) begin
        have_q <= rd_strobe;
        tm_q   <= rd_test;
        lane_q <= rd_lane;
      end
      dout_en <= have_q & ~s_cas & ~s_oe;
      dout    <= tm_q ? {uniform, {(DQ_W-1){1'b1}}} : rdata[lane_q*DQ_W +: DQ_W];
    end
  end
endmodule

// File: rtl/dram_tm_ctrl.sv
`timescale 1ns/1ps
module dram_tm_ctrl
  import dram_tm_pkg::*;
#(
  parameter int DQ_W     = 4,
  parameter int WORD_W   = 8,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 4,
  parameter int REF_BITS = 10,
  parameter int ADDR_W   = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DQ_W-1:0]     din,
  output logic [DQ_W-1:0]     dout,
  output logic                dout_en,
  output logic                test_active,
  output logic [REF_BITS-1:0] ref_row
);
  localparam int LANES  = WORD_W / DQ_W;
  localparam int SEL_W  = $clog2(LANES);
  localparam int WADR_W = ROW_BITS + COL_BITS - SEL_W;
  // word address bits kept in test mode: top row bit and top column bit dropped
  localparam logic [WADR_W-1:0] TM_KEEP =
    ~((WADR_W'(1) << (WADR_W - 1)) | (WADR_W'(1) << (COL_BITS - SEL_W - 1)));

  logic              s_cas, s_we, s_oe, cas_fall, we_fall, ras_rise;
  logic [ADDR_W-1:0] s_addr;
  logic [DQ_W-1:0]   s_din;
  ras_cycle_e        ras_kind;

  strobe_front #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_front (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .s_cas(s_cas), .s_we(s_we), .s_oe(s_oe),
    .s_addr(s_addr), .s_din(s_din), .cas_fall(cas_fall), .we_fall(we_fall),
    .ras_rise(ras_rise), .ras_kind(ras_kind)
  );

  logic                row_act, col_seen;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_act     <= 1'b0;
      col_seen    <= 1'b0;
      test_active <= 1'b0;
      ref_row     <= '0;
      row_q       <= '0;
      col_q       <= '0;
    end else begin
      unique case (ras_kind)
        CYC_ACCESS: begin
          row_act  <= 1'b1;
          col_seen <= 1'b0;
          row_q    <= s_addr[ROW_BITS-1:0];
        end
        CYC_REFRESH: begin
          test_active <= 1'b0;
          ref_row     <= ref_row + 1'b1;
        end
        CYC_TEST_ENTRY: test_active <= 1'b1;
        default: ;
      endcase
      if (ras_rise) begin
        row_act <= 1'b0;
        if (row_act && !col_seen) test_active <= 1'b0;
      end
      if (cas_fall && row_act) begin
        col_seen <= 1'b1;
        col_q    <= s_addr[COL_BITS-1:0];
      end
    end
  end

  logic                acc_go, acc_wr, acc_rd, late_wr, do_wr;
  logic [COL_BITS-1:0] col_now;
  logic [WADR_W-1:0]   full_wa, arr_addr;
  logic [SEL_W-1:0]    lane;
  logic [LANES-1:0]    wr_lane;
  logic [WORD_W-1:0]   wdata, rdata;

  assign acc_go   = cas_fall & row_act;
  assign acc_wr   = acc_go & ~s_we;
  assign acc_rd   = acc_go & s_we;
  assign late_wr  = we_fall & row_act & col_seen & ~s_cas & ~cas_fall;
  assign do_wr    = acc_wr | late_wr;
  assign col_now  = cas_fall ? s_addr[COL_BITS-1:0] : col_q;
  assign full_wa  = {row_q, col_now[COL_BITS-1:SEL_W]};
  assign arr_addr = test_active ? (full_wa & TM_KEEP) : full_wa;
  assign lane     = col_now[SEL_W-1:0];
  assign wdata    = test_active ? {WORD_W{s_din[0]}} : {LANES{s_din}};

  for (genvar i = 0; i < LANES; i++) begin : g_we
    assign wr_lane[i] = do_wr & (test_active | (lane == SEL_W'(i)));
  end

  tm_array #(.LANES(LANES), .DQ_W(DQ_W), .WADR_W(WADR_W)) u_array (
    .clk(clk), .wr_lane(wr_lane), .rd_en(acc_rd), .waddr(arr_addr),
    .wdata(wdata), .rdata(rdata)
  );

  tm_readout #(.LANES(LANES), .DQ_W(DQ_W), .SEL_W(SEL_W)) u_out (
    .clk(clk), .rst(rst), .cas_fall(cas_fall), .rd_strobe(acc_rd),
    .rd_test(test_active), .rd_lane(lane), .s_cas(s_cas), .s_oe(s_oe),
    .rdata(rdata), .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: rtl/dram_tm_ctrl_chk.sv
`timescale 1ns/1ps
module dram_tm_ctrl_chk
  import dram_tm_pkg::*;
#(
  parameter int REF_BITS = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                cas_n,
  input logic                oe_n,
  input logic                dout_en,
  input logic                test_active,
  input logic [REF_BITS-1:0] ref_row,
  input ras_cycle_e          ras_kind
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!dout_en && !test_active && ref_row == '0));

  p_hiz_r3: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> (!$past(cas_n, 2) && !$past(oe_n, 2)));

  p_enter_r4: assert property (@(posedge clk) disable iff (rst)
    ras_kind == CYC_TEST_ENTRY |=> test_active);

  p_stay_off_r4: assert property (@(posedge clk) disable iff (rst)
    (!test_active && ras_kind != CYC_TEST_ENTRY) |=> !test_active);

  p_refresh_r5: assert property (@(posedge clk) disable iff (rst)
    ras_kind == CYC_REFRESH |=>
      (!test_active && ref_row == REF_BITS'($past(ref_row) + 1'b1)));

  p_ref_hold_r5: assert property (@(posedge clk) disable iff (rst)
    ras_kind != CYC_REFRESH |=> $stable(ref_row));
endmodule

bind dram_tm_ctrl dram_tm_ctrl_chk #(.REF_BITS(REF_BITS)) u_chk (.*);

// File: tb/sim_dram_tm_ctrl.sv
`timescale 1ns/1ps
module sim_dram_tm_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [3:0] addr = '0, din = '0;
  logic [3:0] dout;
  logic       dout_en, test_active;
  logic [9:0] ref_row;

  int checks = 0;
  int errors = 0;
  int exp_ref = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dram_tm_ctrl u0 (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .test_active(test_active), .ref_row(ref_row)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic row_open(logic [3:0] r);
    addr = r; tick(1); ras_n = 1'b0; tick(2);
  endtask

  task automatic row_close();
    ras_n = 1'b1; tick(3);
  endtask

  task automatic col_read(logic [3:0] c, output logic [3:0] d, output logic en);
    addr = c; we_n = 1'b1; tick(1);
    cas_n = 1'b0; tick(4);
    d = dout; en = dout_en;
    cas_n = 1'b1; tick(3);
  endtask

  task automatic col_write(logic [3:0] c, logic [3:0] v, output logic en);
    addr = c; din = v; we_n = 1'b0; tick(1);
    cas_n = 1'b0; tick(4);
    en = dout_en;
    cas_n = 1'b1; we_n = 1'b1; tick(3);
  endtask

  task automatic wr1(logic [3:0] r, logic [3:0] c, logic [3:0] v);
    logic en;
    row_open(r); col_write(c, v, en); row_close();
  endtask

  task automatic rd1(logic [3:0] r, logic [3:0] c, output logic [3:0] d);
    logic en;
    row_open(r); col_read(c, d, en); row_close();
  endtask

  task automatic strobe_before_row(logic we_low);
    cas_n = 1'b0; we_n = ~we_low; tick(2);
    ras_n = 1'b0; tick(3);
    cas_n = 1'b1; we_n = 1'b1; tick(2);
    ras_n = 1'b1; tick(3);
  endtask

  task automatic t_reset();
    chk("R1 dout_en", dout_en, 0);
    chk("R1 test_active", test_active, 0);
    chk("R1 ref_row", ref_row, 0);
  endtask

  task automatic t_normal_rw();
    logic [3:0] d; logic en;
    wr1(4'd1, 4'd2, 4'hA);
    wr1(4'd1, 4'd3, 4'h5);
    rd1(4'd1, 4'd2, d); chk("R2 low nibble", d, 4'hA);
    rd1(4'd1, 4'd3, d); chk("R2 high nibble", d, 4'h5);
    chk("R3 released after CAS high", dout_en, 0);
    row_open(4'd1);
    col_read(4'd3, d, en); chk("R3 driven when CAS and OE low", en, 1);
    oe_n = 1'b1;
    col_read(4'd3, d, en); chk("R3 OE high", en, 0);
    oe_n = 1'b0;
    col_write(4'd6, 4'h3, en); chk("R3 write cycle", en, 0);
    row_close();
  endtask

  task automatic t_page_late();
    logic [3:0] d; logic en;
    row_open(4'd2);
    col_write(4'd4, 4'h3, en);
    col_write(4'd5, 4'hC, en);
    // read then late write on column 6
    addr = 4'd6; we_n = 1'b1; tick(1);
    cas_n = 1'b0; tick(3);
    din = 4'h9; we_n = 1'b0; tick(3);
    we_n = 1'b1; cas_n = 1'b1; tick(3);
    col_read(4'd4, d, en); chk("R10 page col 4", d, 4'h3);
    col_read(4'd5, d, en); chk("R10 page col 5", d, 4'hC);
    col_read(4'd6, d, en); chk("R10 late write", d, 4'h9);
    row_close();
  endtask

  task automatic t_fail_pattern();
    logic [3:0] d;
    wr1(4'd3, 4'd0, 4'hF);
    wr1(4'd3, 4'd1, 4'h0);
    wr1(4'd3, 4'd2, 4'h0);
    wr1(4'd3, 4'd3, 4'h8);
    wr1(4'd5, 4'd10, 4'h6);
    strobe_before_row(1'b1 == 1'b1);
    chk("R4 entry", test_active, 1);
    chk("R4 counter unchanged", ref_row, exp_ref);
    rd1(4'd3, 4'd0, d); chk("R8 fail mixed nibbles", d, 4'h7);
    rd1(4'd7, 4'd9, d); chk("R9 aliased fail", d, 4'h7);
    rd1(4'd3, 4'd2, d); chk("R8 fail single bit", d, 4'h7);
  endtask

  task automatic t_test_write();
    logic [3:0] d; logic en;
    wr1(4'd1, 4'd2, 4'b1110);
    rd1(4'd1, 4'd3, d); chk("R8 pass all zero", d, 4'hF);
    strobe_before_row(1'b0);
    exp_ref++;
    chk("R5 exit", test_active, 0);
    chk("R5 counter", ref_row, exp_ref);
    rd1(4'd1, 4'd2, d); chk("R7 low nibble zero", d, 4'h0);
    rd1(4'd1, 4'd3, d); chk("R7 high nibble zero", d, 4'h0);
    rd1(4'd5, 4'd10, d); chk("R9 real address untouched", d, 4'h6);
    strobe_before_row(1'b1);
    chk("R4 re-entry", test_active, 1);
    wr1(4'd5, 4'd10, 4'b0001);
    rd1(4'd1, 4'd2, d); chk("R8 pass all one", d, 4'hF);
    row_open(4'd0); row_close();
    chk("R6 row-only exit", test_active, 0);
    chk("R6 counter unchanged", ref_row, exp_ref);
    rd1(4'd1, 4'd2, d); chk("R9 alias wrote low nibble", d, 4'hF);
    rd1(4'd1, 4'd3, d); chk("R9 alias wrote high nibble", d, 4'hF);
    rd1(4'd5, 4'd10, d); chk("R9 real address still", d, 4'h6);
    row_open(4'd0); col_read(4'd0, d, en); row_close();
    chk("R6 normal cycle keeps mode", test_active, 0);
  endtask

  task automatic t_hidden();
    strobe_before_row(1'b1);
    chk("R11 setup entry", test_active, 1);
    row_open(4'd1);
    addr = 4'd2; we_n = 1'b1; tick(1);
    cas_n = 1'b0; tick(4);
    chk("R11 read driven", dout_en, 1);
    ras_n = 1'b1; tick(3);
    ras_n = 1'b0; tick(4);
    exp_ref++;
    chk("R11 exit", test_active, 0);
    chk("R11 counter", ref_row, exp_ref);
    chk("R11 still driven", dout_en, 1);
    chk("R11 data held", dout, 4'hF);
    cas_n = 1'b1; tick(3);
    chk("R3 released after hidden", dout_en, 0);
    ras_n = 1'b1; tick(3);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_normal_rw();
    t_page_late();
    t_fail_pattern();
    t_test_write();
    t_hidden();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule